// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block translates 32-bit virtual addresses into 32-bit physical addresses for a processor core, using a fully associative set of entries that software loads on demand. Every entry pairs a virtual page number with an 8-bit address-space identifier and carries its own page size. Mappings from several processes can therefore stay resident at once, and a context switch needs no flush. A lookup that finds nothing raises a miss. No hardware table walk follows: the operating system refills the buffer through the write port and retries the access.

A lookup presents an address, the current address-space identifier and the kind of access. The tag compare is combinational, and the physical address, permissions, storage attributes and the miss and fault flags are registered on the following clock edge. Instruction fetches and data accesses have separate translation enables, and an interrupt-entry input forces translation off. With translation off, addresses pass through untranslated.

Top module: `pid_tlb`

## Requirements
- R1: After reset every entry is invalid and res_valid is 0, so with translation on every lookup misses until an entry is written.
- R2: An entry hits when it is valid, its identifier equals lk_pid, and the address bits above its page offset equal the same bits of its page number. On a hit, res_pa takes the upper bits from the entry's frame number and the offset bits from lk_va.
- R3: The 3-bit size code s selects a page of 1 KB times 4 to the power s, from 1 KB (s=0) to 16 MB (s=7). The offset is then the low 10+2s bits of the address.
- R4: On a miss with translation on, res_miss is 1, res_fault is 0, res_pa is 0, res_perm is 000 and res_attr is 00.
- R5: res_perm is {execute, write, read}. Access kind 00 (load) and 11 (treated as load) need read, 01 (store) needs write and 10 (fetch) needs execute. A hit that lacks the needed right sets res_fault and still returns the translated address.
- R6: A fetch uses inst_xlate_en and every other kind uses data_xlate_en. When that enable is 0, or when irq_entry is 1, res_pa equals lk_va, res_miss and res_fault are 0, res_perm is 111 and res_attr is 00.
- R7: The result of a lookup appears on the clock edge after lk_valid is sampled, and res_valid is 1 for exactly those cycles.
- R8: wr_en loads entry wr_idx. The tag word holds the page number in bits 31:10, the size code in 9:7 and the valid bit in 6. The data word holds the frame number in 31:10, the attributes in 4:3 and {execute, write, read} in 2:0. wr_pid supplies the identifier. Writing an index again replaces its previous contents.
- R9: inv_all clears every valid bit in one cycle and takes priority over a wr_en in the same cycle.
- R10: When several entries hit, the one with the lowest index supplies the result.
- R11: Entries holding the same page under different identifiers coexist, and a lookup matches only the entry tagged with its own identifier.
- R12: A lookup made in the same cycle as a write sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_pid | input | 8 | Current address-space identifier |
| lk_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 load |
| inst_xlate_en | input | 1 | Translation enable for fetches |
| data_xlate_en | input | 1 | Translation enable for loads and stores |
| irq_entry | input | 1 | Forces translation off |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 32 | Tag word: page number, size code, valid |
| wr_data | input | 32 | Data word: frame number, attributes, permissions |
| wr_pid | input | 8 | Identifier stored with the entry |
| inv_all | input | 1 | Invalidate all entries |
| res_valid | output | 1 | Registered result is present |
| res_pa | output | 32 | Physical address |
| res_perm | output | 3 | {execute, write, read} |
| res_attr | output | 2 | Storage attributes of the entry |
| res_miss | output | 1 | No entry matched |
| res_fault | output | 1 | Access kind not permitted |

## Verification
Each of the eight size codes is tried with the lowest and highest addresses inside a page and with the first address of the following page. Junk bits placed below the page boundary in both the page number and the frame number separate a compare or substitution that uses the wrong number of bits. A sweep of all permission codes against all four access kinds shows which right each kind needs. Lookups repeated with the enables cleared, with irq_entry set and under two identifiers show pass-through and context separation. Overlapping entries, same-cycle write and lookup, and invalidate-all together with a write show lowest-index priority and the ordering of updates.

// File: rtl/pid_tlb.sv
module pid_tlb #(
  parameter int ENTRIES = 64,
  parameter int PIDW    = 8,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [31:0]     lk_va,
  input  logic [PIDW-1:0] lk_pid,
  input  logic [1:0]      lk_kind,
  input  logic            inst_xlate_en,
  input  logic            data_xlate_en,
  input  logic            irq_entry,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [31:0]     wr_tag,
  input  logic [31:0]     wr_data,
  input  logic [PIDW-1:0] wr_pid,
  input  logic            inv_all,
  output logic            res_valid,
  output logic [31:0]     res_pa,
  output logic [2:0]      res_perm,
  output logic [1:0]      res_attr,
  output logic            res_miss,
  output logic            res_fault
);

  logic [ENTRIES-1:0] vld;
  logic [21:0]        epn  [ENTRIES];
  logic [2:0]         sz   [ENTRIES];
  logic [PIDW-1:0]    tpid [ENTRIES];
  logic [21:0]        rpn  [ENTRIES];
  logic [4:0]         prop [ENTRIES];

  wire unused_bits = ^{wr_tag[5:0], wr_data[9:5]};

  always_ff @(posedge clk) begin
    if (!rst_n)       vld <= '0;
    else if (inv_all) vld <= '0;
    else if (wr_en)   vld[wr_idx] <= wr_tag[6];
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inv_all) begin
      epn[wr_idx]  <= wr_tag[31:10];
      sz[wr_idx]   <= wr_tag[9:7];
      tpid[wr_idx] <= wr_pid;
      rpn[wr_idx]  <= wr_data[31:10];
      prop[wr_idx] <= wr_data[4:0];
    end
  end

  logic [ENTRIES-1:0] hit;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    wire [4:0]  sh  = 5'd10 + {1'b0, sz[i], 1'b0};
    wire [31:0] msk = 32'hFFFF_FFFF << sh;
    assign hit[i] = vld[i] && (tpid[i] == lk_pid) &&
                    (((lk_va ^ {epn[i], 10'b0}) & msk) == 32'h0);
  end

  logic [IW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit[i]) sel = IW'(i);
  end

  wire        found   = |hit;
  wire        xon     = !irq_entry && ((lk_kind == 2'b10) ? inst_xlate_en : data_xlate_en);
  wire [4:0]  sel_sh  = 5'd10 + {1'b0, sz[sel], 1'b0};
  wire [31:0] sel_msk = 32'hFFFF_FFFF << sel_sh;
  wire [31:0] hit_pa  = ({rpn[sel], 10'b0} & sel_msk) | (lk_va & ~sel_msk);
  wire [2:0]  sel_pm  = prop[sel][2:0];
  wire        allowed = (lk_kind == 2'b01) ? sel_pm[1] :
                        (lk_kind == 2'b10) ? sel_pm[2] : sel_pm[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pa    <= '0;
      res_perm  <= '0;
      res_attr  <= '0;
      res_miss  <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        if (!xon) begin
          res_pa    <= lk_va;
          res_perm  <= 3'b111;
          res_attr  <= 2'b00;
          res_miss  <= 1'b0;
          res_fault <= 1'b0;
        end else if (!found) begin
          res_pa    <= '0;
          res_perm  <= 3'b000;
          res_attr  <= 2'b00;
          res_miss  <= 1'b1;
          res_fault <= 1'b0;
        end else begin
          res_pa    <= hit_pa;
          res_perm  <= sel_pm;
          res_attr  <= prop[sel][4:3];
          res_miss  <= 1'b0;
          res_fault <= !allowed;
        end
      end
    end
  end

  a_r4_miss_not_fault: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_miss && res_fault));

  a_r4_miss_no_rights: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> (res_perm == 3'b000));

  a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !xon) |=> (res_pa == $past(lk_va) && !res_miss && !res_fault));

  a_r7_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);

  a_r9_flush_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && xon && $past(inv_all)) |=> res_miss);

endmodule

// File: tb/sim_pid_tlb.sv
module sim_pid_tlb;
  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0;
  logic [31:0] lk_va = 0;
  logic [7:0]  lk_pid = 0;
  logic [1:0]  lk_kind = 0;
  logic        inst_xlate_en = 0, data_xlate_en = 0, irq_entry = 0;
  logic        wr_en = 0;
  logic [5:0]  wr_idx = 0;
  logic [31:0] wr_tag = 0, wr_data = 0;
  logic [7:0]  wr_pid = 0;
  logic        inv_all = 0;
  logic        res_valid, res_miss, res_fault;
  logic [31:0] res_pa;
  logic [2:0]  res_perm;
  logic [1:0]  res_attr;

  pid_tlb u0 (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  logic        m_v   [64];
  logic [31:0] m_tag [64];
  logic [31:0] m_dat [64];
  logic [7:0]  m_pid [64];

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string rq, logic [39:0] act, logic [39:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] tag, logic [31:0] dat, logic [7:0] pid);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(idx); wr_tag = tag; wr_data = dat; wr_pid = pid;
    @(negedge clk);
    wr_en = 0;
    m_v[idx] = tag[6]; m_tag[idx] = tag; m_dat[idx] = dat; m_pid[idx] = pid;
  endtask

  task automatic flush();
    @(negedge clk);
    inv_all = 1;
    @(negedge clk);
    inv_all = 0;
    for (int i = 0; i < 64; i++) m_v[i] = 0;
  endtask

  function automatic logic [39:0] expect_res(logic [31:0] va, logic [7:0] pid, logic [1:0] kind,
                                             logic ie, logic de, logic irq);
    logic xon;
    int w;
    logic [31:0] om;
    logic [2:0] pm;
    logic need;
    xon = !irq && ((kind == 2'b10) ? ie : de);
    if (!xon) return {1'b1, 1'b0, 1'b0, 3'b111, 2'b00, va};
    w = -1;
    for (int i = 63; i >= 0; i--) begin
      om = (32'h1 << (10 + 2 * int'(m_tag[i][9:7]))) - 1;
      if (m_v[i] && m_pid[i] == pid && ((va ^ m_tag[i]) & ~om) == 0) w = i;
    end
    if (w < 0) return {1'b1, 1'b1, 1'b0, 3'b000, 2'b00, 32'h0};
    om = (32'h1 << (10 + 2 * int'(m_tag[w][9:7]))) - 1;
    pm = m_dat[w][2:0];
    need = (kind == 2'b01) ? pm[1] : (kind == 2'b10) ? pm[2] : pm[0];
    return {1'b1, 1'b0, !need, pm, m_dat[w][4:3], (m_dat[w] & ~om) | (va & om)};
  endfunction

  task automatic look(string rq, logic [31:0] va, logic [7:0] pid, logic [1:0] kind,
                      logic ie = 1, logic de = 1, logic irq = 0);
    logic [39:0] e;
    e = expect_res(va, pid, kind, ie, de, irq);
    lk_valid = 1; lk_va = va; lk_pid = pid; lk_kind = kind;
    inst_xlate_en = ie; data_xlate_en = de; irq_entry = irq;
    @(negedge clk);
    if (wr_en) begin
      wr_en = 0;
      m_v[wr_idx] = wr_tag[6]; m_tag[wr_idx] = wr_tag; m_dat[wr_idx] = wr_data; m_pid[wr_idx] = wr_pid;
    end
    lk_valid = 0;
    chk(rq, {res_valid, res_miss, res_fault, res_perm, res_attr, res_pa}, e);
  endtask

  initial begin
    logic [31:0] base, top;
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_tag[i] = 0; m_dat[i] = 0; m_pid[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R7 reset res_valid", {39'h0, res_valid}, 40'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R7 idle res_valid", {39'h0, res_valid}, 40'h0);
    look("R1 empty after reset", 32'h1234_5678, 8'h00, 2'b00);
    look("R1 empty after reset fetch", 32'hFFFF_FFFC, 8'h07, 2'b10);

    // R6 pass-through variants
    wr(0, 32'h8000_0000 | 32'h40, 32'h0000_0007, 8'h01);
    look("R6 fetch with inst off", 32'h8000_0124, 8'h01, 2'b10, 0, 1, 0);
    look("R6 load with data off", 32'h8000_0124, 8'h01, 2'b00, 1, 0, 0);
    look("R6 store with inst off only", 32'h8000_0124, 8'h01, 2'b01, 0, 1, 0);
    look("R6 irq entry forces off", 32'h8000_0124, 8'h01, 2'b00, 1, 1, 1);

    // R2/R3 size sweep, junk below page boundary in tag and frame
    for (int s = 0; s < 8; s++) begin
      flush();
      wr(5, 32'hA50A_B400 | (32'(s) << 7) | 32'h40, 32'h3C0F_FC00 | 32'h1B, 8'h03);
      base = 32'hA50A_B400 & ~((32'h1 << (10 + 2 * s)) - 1);
      top  = base + (32'h1 << (10 + 2 * s)) - 4;
      look("R3 page start hit", base, 8'h03, 2'b00);
      look("R2 page end hit", top, 8'h03, 2'b00);
      look("R3 next page miss", top + 4, 8'h03, 2'b00);
      look("R2 below page miss", base - 4, 8'h03, 2'b00);
    end

    // R11 identifiers
    flush();
    wr(5, 32'h0040_0000 | (32'd1 << 7) | 32'h40, 32'h1111_1000 | 32'h07, 8'h03);
    look("R11 other pid misses", 32'h0040_0204, 8'h04, 2'b00);
    wr(6, 32'h0040_0000 | (32'd1 << 7) | 32'h40, 32'h2222_2000 | 32'h0F, 8'h04);
    look("R11 pid 3 mapping", 32'h0040_0204, 8'h03, 2'b00);
    look("R11 pid 4 mapping", 32'h0040_0204, 8'h04, 2'b00);

    // R5 permission sweep
    for (int p = 0; p < 8; p++) begin
      wr(0, 32'h7000_0000 | 32'h40, 32'h0BAD_0000 | 32'(p) | 32'h10, 8'h09);
      for (int k = 0; k < 4; k++)
        look("R5 rights by kind", 32'h7000_0010 + 32'(k), 8'h09, 2'(k));
    end

    // R10 lowest index wins, R8 replace
    flush();
    wr(20, 32'h0600_0000 | (32'd7 << 7) | 32'h40, 32'hB000_0000 | 32'h01, 8'h02);
    wr(10, 32'h0600_0000 | (32'd2 << 7) | 32'h40, 32'hC000_0000 | 32'h1A, 8'h02);
    look("R10 lowest of two", 32'h0600_0F00, 8'h02, 2'b01);
    look("R10 only higher covers", 32'h0680_0000, 8'h02, 2'b00);
    wr(10, 32'h0600_0000 | (32'd2 << 7), 32'h0, 8'h02);
    look("R8 rewrite invalidates", 32'h0600_0F00, 8'h02, 2'b00);
    wr(63, 32'hFFFF_FC00 | 32'h40, 32'h0001_0400 | 32'h05, 8'hFF);
    look("R8 last index", 32'hFFFF_FFFC, 8'hFF, 2'b10);

    // R12 write and lookup in one cycle
    @(negedge clk);
    wr_en = 1; wr_idx = 6'd20; wr_tag = 32'h0600_0000 | (32'd7 << 7) | 32'h40;
    wr_data = 32'hD000_0000 | 32'h07; wr_pid = 8'h02;
    look("R12 old contents seen", 32'h0612_3450, 8'h02, 2'b01);
    look("R12 new contents after", 32'h0612_3450, 8'h02, 2'b01);

    // R9 invalidate-all beats write
    @(negedge clk);
    inv_all = 1; wr_en = 1; wr_idx = 6'd1; wr_tag = 32'h0900_0000 | 32'h40;
    wr_data = 32'h0A00_0007; wr_pid = 8'h02;
    @(negedge clk);
    inv_all = 0; wr_en = 0;
    for (int i = 0; i < 64; i++) m_v[i] = 0;
    look("R9 flushed entry", 32'h0612_3450, 8'h02, 2'b00);
    look("R9 write dropped", 32'h0900_0000, 8'h02, 2'b00);
    look("R9 last index flushed", 32'hFFFF_FFFC, 8'hFF, 2'b10);

    @(negedge clk);
    chk("R7 idle after lookups", {39'h0, res_valid}, 40'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule